// File: doc/BRIEF.md
# Debug Program Buffer Command Engine

This block is the abstract-command engine of a debug module for a RISC-V style core, with a small program buffer attached. A debugger reaches it through a simple register bus. Over that bus the debugger loads buffer words, loads and reads the `data0` register, clears errors and issues commands. An Access Register command moves one word between `data0` and a general-purpose register (GPR) of the halted core. When the command asks for post-execution, the block then feeds the buffered instructions to the core one at a time through an instruction injection port. After the last word it supplies an ebreak by itself, so the core hands control back to debug mode.

This is how a debugger reaches memory. It stores a load or a store in the buffer, puts an address in a GPR through a transfer, and lets post-execution run the access. A fault raised by an injected instruction stops the sequence and leaves error code 3.

Register bus rules: a write completes in the cycle `dbg_valid` and `dbg_write` are high, and there is no back-pressure. A read is combinational from `dbg_addr` and has no side effects.

Injection stream rules: `inj_valid` qualifies `inj_instr`. Both stay asserted and unchanged until the core returns `inj_done` or `inj_exc` for one cycle. That response acts as the ready of the handshake, and only one instruction is outstanding at a time.

Top module: `dm_progbuf_engine`

## Requirements
- R1: Program buffer word k sits at register address 0x20+k, for k below `PBUF_WORDS`. Each word is writable and reads back what was written.
- R2: The abstract status register at 0x16 reports the buffer size in bits 28:24 and the data register count (1) in bits 3:0. The debug status register at 0x11 reads bit 22 (implicit ebreak) as 1.
- R3: A command is written at 0x17. Its fields are kind in bits 31:24 (must be 0), size in bits 22:20 (must be 2), bits 23 and 19 (must be 0), post-execution in bit 18, transfer in bit 17, write in bit 16 and register number in bits 15:0. With transfer=1 and write=1, `data0` (address 0x04) is written to the GPR numbered regno-0x1000.
- R4: With transfer=1 and write=0, the selected GPR is copied into `data0`.
- R5: With post-execution=1, the buffer words are injected in ascending order only after the register transfer has completed. They are followed by ebreak 0x00100073. With post-execution=0 nothing is injected.
- R6: `inj_valid` and `inj_instr` stay asserted and stable until the core returns `inj_done` or `inj_exc`.
- R7: If the core answers `inj_exc`, injection stops at once and no further word or ebreak is issued. The error field becomes 3 if it was 0.
- R8: Busy (bit 12 of 0x16) reads 1 from the cycle after a command is accepted until the transfer and any injection are over.
- R9: A write to the command, `data0` or a buffer word while busy is ignored. It sets the error field (bits 10:8 of 0x16) to 1 if that field was 0.
- R10: While the error field is nonzero, a command write is ignored. Writing 1s to bits 10:8 of 0x16 clears the matching error bits.
- R11: A command with a nonzero kind is not supported. So is a transfer whose size is not 2, whose bits 23 or 19 are set, or whose regno lies outside 0x1000 to 0x1000+`NGPR`-1. Such a command sets the error field to 2 and touches no GPR and injects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_valid | input | 1 | Register bus write strobe qualifier |
| dbg_write | input | 1 | Register bus access is a write |
| dbg_addr | input | 7 | Register address |
| dbg_wdata | input | 32 | Register write data |
| dbg_rdata | output | 32 | Register read data for `dbg_addr` |
| gpr_we | output | 1 | GPR write enable to the core |
| gpr_idx | output | $clog2(NGPR) | GPR index |
| gpr_wdata | output | 32 | GPR write data |
| gpr_rdata | input | 32 | GPR read data from the core for `gpr_idx` |
| inj_valid | output | 1 | Injected instruction valid |
| inj_instr | output | 32 | Injected instruction |
| inj_done | input | 1 | Core finished the injected instruction |
| inj_exc | input | 1 | Injected instruction raised an exception |

## Verification
The engine is driven with four kinds of command:
- A transfer without post-execution, which shows that data moves with no injection.
- A write transfer with post-execution, in which the GPR value is checked at the first injection to separate transfer-then-execute from the reverse order.
- A post-execution-only command.
- A buffer holding a faulting word, which separates a clean stop from running on into the ebreak.

Core latencies of 0 and several cycles test the handshake hold. Bus writes placed inside a busy window, commands issued with a pending error, and out-of-range or malformed register numbers separate "ignored with an error" from "acted upon".

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam logic [6:0] ADR_DATA0  = 7'h04;
  localparam logic [6:0] ADR_STATUS = 7'h11;
  localparam logic [6:0] ADR_ABSCS  = 7'h16;
  localparam logic [6:0] ADR_CMD    = 7'h17;
  localparam logic [6:0] ADR_PBUF   = 7'h20;

  localparam logic [31:0] EBREAK_INSN = 32'h0010_0073;
  localparam logic [15:0] GPR_BASE    = 16'h1000;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_BUSY  = 3'd1,
    ERR_UNSUP = 3'd2,
    ERR_EXC   = 3'd3
  } cmderr_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_EXEC = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic [7:0]  kind;
    logic        rsv_hi;
    logic [2:0]  size;
    logic        postinc;
    logic        postexec;
    logic        transfer;
    logic        write;
    logic [15:0] regno;
  } cmd_word_t;
endpackage

// File: rtl/dm_cmd_decode.sv
module dm_cmd_decode
  import dm_pkg::*;
#(
  parameter int NGPR = 32,
  localparam int GW = $clog2(NGPR)
) (
  input  logic [31:0]   word,
  output logic          supported,
  output logic          postexec,
  output logic          transfer,
  output logic          write,
  output logic [GW-1:0] gidx
);
  cmd_word_t   c;
  logic [15:0] off;
  logic        in_range;
  logic        xfer_ok;

  always_comb begin
    c         = cmd_word_t'(word);
    off       = c.regno - GPR_BASE;
    in_range  = off < 16'(NGPR);
    xfer_ok   = in_range && (c.size == 3'd2) && !c.rsv_hi && !c.postinc;
    supported = (c.kind == 8'd0) && (!c.transfer || xfer_ok);
    postexec  = c.postexec;
    transfer  = c.transfer;
    write     = c.write;
    gidx      = off[GW-1:0];
  end
endmodule

// File: rtl/dm_pbuf_store.sv
module dm_pbuf_store #(
  parameter int WORDS = 2,
  parameter int DW    = 32,
  localparam int PW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] ridx,
  output logic [DW-1:0] rdata,
  input  logic [CW-1:0] sidx,
  output logic [DW-1:0] sdata
);
  logic [DW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         word_q <= '0;
      else if (we && widx == PW'(g))      word_q <= wdata;
    end
    assign words[g] = word_q;
  end

  always_comb begin
    rdata = '0;
    sdata = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (ridx == PW'(i)) rdata = words[i];
      if (sidx == CW'(i)) sdata = words[i];
    end
  end
endmodule

// File: rtl/dm_inject_seq.sv
module dm_inject_seq
  import dm_pkg::*;
#(
  parameter int WORDS = 2,
  parameter int DW    = 32,
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [CW-1:0] slot,
  input  logic [DW-1:0] slot_data,
  output logic          inj_valid,
  output logic [DW-1:0] inj_instr,
  input  logic          inj_done,
  input  logic          inj_exc,
  output logic          fin,
  output logic          fin_exc
);
  localparam logic [CW-1:0] LAST = CW'(WORDS);

  logic active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      slot    <= '0;
      fin     <= 1'b0;
      fin_exc <= 1'b0;
    end else begin
      fin     <= 1'b0;
      fin_exc <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        slot   <= '0;
      end else if (active && inj_exc) begin
        active  <= 1'b0;
        fin     <= 1'b1;
        fin_exc <= 1'b1;
      end else if (active && inj_done) begin
        if (slot == LAST) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end else begin
          slot <= slot + CW'(1);
        end
      end
    end
  end

  assign inj_valid = active;
  assign inj_instr = (slot == LAST) ? EBREAK_INSN : slot_data;

  a_r6_hold_instr: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && !inj_done && !inj_exc |=> inj_valid && $stable(inj_instr));

  a_r7_stop_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && inj_exc |=> !inj_valid && fin_exc);

  a_r5_ebreak_ends: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid && inj_done && !inj_exc && inj_instr == EBREAK_INSN |=> !inj_valid && fin);
endmodule

// File: rtl/dm_progbuf_engine.sv
module dm_progbuf_engine
  import dm_pkg::*;
#(
  parameter int PBUF_WORDS = 2,
  parameter int NGPR       = 32,
  localparam int DW = 32,
  localparam int GW = $clog2(NGPR),
  localparam int PW = (PBUF_WORDS > 1) ? $clog2(PBUF_WORDS) : 1,
  localparam int CW = $clog2(PBUF_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_valid,
  input  logic          dbg_write,
  input  logic [6:0]    dbg_addr,
  input  logic [31:0]   dbg_wdata,
  output logic [31:0]   dbg_rdata,
  output logic          gpr_we,
  output logic [GW-1:0] gpr_idx,
  output logic [31:0]   gpr_wdata,
  input  logic [31:0]   gpr_rdata,
  output logic          inj_valid,
  output logic [31:0]   inj_instr,
  input  logic          inj_done,
  input  logic          inj_exc
);
  eng_state_e    state;
  cmderr_e       cmderr;
  logic [DW-1:0] data0;
  logic          busy;

  logic          l_post, l_xfer, l_write;
  logic [GW-1:0] l_gidx;

  logic          d_ok, d_post, d_xfer, d_write;
  logic [GW-1:0] d_gidx;

  logic          wr, wr_data0, wr_cmd, wr_abscs, wr_pbuf, busy_hit, accept;
  logic [6:0]    pofs;
  logic [PW-1:0] pidx;
  logic [DW-1:0] pbuf_rdata, slot_data;
  logic [CW-1:0] slot;
  logic          seq_start, seq_fin, seq_fin_exc;

  assign busy     = (state != ST_IDLE);
  assign wr       = dbg_valid && dbg_write;
  assign wr_data0 = wr && dbg_addr == ADR_DATA0;
  assign wr_cmd   = wr && dbg_addr == ADR_CMD;
  assign wr_abscs = wr && dbg_addr == ADR_ABSCS;
  assign pofs     = dbg_addr - ADR_PBUF;
  assign wr_pbuf  = wr && dbg_addr >= ADR_PBUF && pofs < 7'(PBUF_WORDS);
  assign pidx     = pofs[PW-1:0];
  assign busy_hit = busy && (wr_data0 || wr_cmd || wr_pbuf);
  assign accept   = !busy && wr_cmd && cmderr == ERR_NONE;

  dm_cmd_decode #(.NGPR(NGPR)) u_dec (
    .word      (dbg_wdata),
    .supported (d_ok),
    .postexec  (d_post),
    .transfer  (d_xfer),
    .write     (d_write),
    .gidx      (d_gidx)
  );

  dm_pbuf_store #(.WORDS(PBUF_WORDS), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_pbuf && !busy),
    .widx  (pidx),
    .wdata (dbg_wdata),
    .ridx  (pidx),
    .rdata (pbuf_rdata),
    .sidx  (slot),
    .sdata (slot_data)
  );

  dm_inject_seq #(.WORDS(PBUF_WORDS), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_start),
    .slot      (slot),
    .slot_data (slot_data),
    .inj_valid (inj_valid),
    .inj_instr (inj_instr),
    .inj_done  (inj_done),
    .inj_exc   (inj_exc),
    .fin       (seq_fin),
    .fin_exc   (seq_fin_exc)
  );

  // command sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      l_post  <= 1'b0;
      l_xfer  <= 1'b0;
      l_write <= 1'b0;
      l_gidx  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept && d_ok) begin
          state   <= ST_XFER;
          l_post  <= d_post;
          l_xfer  <= d_xfer;
          l_write <= d_write;
          l_gidx  <= d_gidx;
        end
        ST_XFER: state <= l_post ? ST_EXEC : ST_IDLE;
        ST_EXEC: if (seq_fin) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign seq_start = (state == ST_XFER) && l_post;
  assign gpr_we    = (state == ST_XFER) && l_xfer && l_write;
  assign gpr_idx   = l_gidx;
  assign gpr_wdata = data0;

  // data0: bus writes when idle, GPR reads during the transfer stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  data0 <= '0;
    else if (state == ST_XFER && l_xfer && !l_write) data0 <= gpr_rdata;
    else if (wr_data0 && !busy)                  data0 <= dbg_wdata;
  end

  // error field: sets only from zero, write-1-to-clear otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmderr <= ERR_NONE;
    else if (cmderr == ERR_NONE && busy_hit)             cmderr <= ERR_BUSY;
    else if (accept && !d_ok)                            cmderr <= ERR_UNSUP;
    else if (cmderr == ERR_NONE && seq_fin && seq_fin_exc) cmderr <= ERR_EXC;
    else if (wr_abscs) cmderr <= cmderr_e'(cmderr & ~dbg_wdata[10:8]);
  end

  always_comb begin
    dbg_rdata = '0;
    if (dbg_addr == ADR_DATA0) begin
      dbg_rdata = data0;
    end else if (dbg_addr == ADR_ABSCS) begin
      dbg_rdata[28:24] = 5'(PBUF_WORDS);
      dbg_rdata[12]    = busy;
      dbg_rdata[10:8]  = cmderr;
      dbg_rdata[3:0]   = 4'd1;
    end else if (dbg_addr == ADR_STATUS) begin
      dbg_rdata[22] = 1'b1;
    end else if (dbg_addr >= ADR_PBUF && pofs < 7'(PBUF_WORDS)) begin
      dbg_rdata = pbuf_rdata;
    end
  end

  a_r5_no_inject_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_XFER |-> !inj_valid);

  a_r8_busy_while_inject: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> busy);

  a_r3_gpr_write_only_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> state == ST_XFER && !inj_valid);

  a_r9_data0_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && state != ST_XFER && wr_data0 |=> $stable(data0));

  a_r10_blocked_by_error: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && wr_cmd && cmderr != ERR_NONE |=> !busy);

  a_r11_unsup_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !d_ok |=> !busy && cmderr == ERR_UNSUP);
endmodule

// File: tb/sim_dm_progbuf_engine.sv
module sim_dm_progbuf_engine;
  localparam logic [6:0] A_DATA0 = 7'h04, A_STAT = 7'h11, A_ABS = 7'h16, A_CMD = 7'h17;
  localparam logic [6:0] A_PB0 = 7'h20, A_PB1 = 7'h21;
  localparam logic [31:0] EBRK  = 32'h0010_0073;
  localparam logic [31:0] LW_S0 = 32'h0004_2403;
  localparam logic [31:0] SW_S1 = 32'h0094_2023;
  localparam logic [31:0] FAULT = 32'hFFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic dbg_valid = 0, dbg_write = 0;
  logic [6:0] dbg_addr = '0;
  logic [31:0] dbg_wdata = '0, dbg_rdata;
  logic gpr_we;
  logic [4:0] gpr_idx;
  logic [31:0] gpr_wdata, gpr_rdata;
  logic inj_valid;
  logic [31:0] inj_instr;
  logic inj_done = 0, inj_exc = 0;

  int n_chk = 0, n_fail = 0, inj_cnt = 0, core_lat = 0, lat_cnt = 0;
  logic [31:0] regs [32];
  logic [31:0] exp_q [$];
  logic order_armed = 0;
  int order_reg = 0;
  logic [31:0] order_val = '0;

  always #4 clk = ~clk;

  dm_progbuf_engine u0 (
    .clk(clk), .rst_n(rst_n), .dbg_valid(dbg_valid), .dbg_write(dbg_write),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_wdata(gpr_wdata), .gpr_rdata(gpr_rdata),
    .inj_valid(inj_valid), .inj_instr(inj_instr), .inj_done(inj_done), .inj_exc(inj_exc)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // core model: register file
  assign gpr_rdata = regs[gpr_idx];
  always @(posedge clk) if (gpr_we) regs[gpr_idx] <= gpr_wdata;

  // core model: injection responder and scoreboard monitor
  always @(negedge clk) begin
    inj_done <= 1'b0;
    inj_exc  <= 1'b0;
    if (inj_valid && !inj_done && !inj_exc) begin
      if (lat_cnt >= core_lat) begin
        lat_cnt = 0;
        inj_cnt++;
        if (order_armed) begin
          order_armed = 0;
          chk(regs[order_reg] == order_val, "R5 transfer done before first injection", regs[order_reg], order_val);
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R7 unexpected injection", inj_instr, 32'h0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(inj_instr == e, "R5 injected instruction order", inj_instr, e);
        end
        if (inj_instr == FAULT) inj_exc <= 1'b1;
        else                    inj_done <= 1'b1;
      end else begin
        lat_cnt++;
      end
    end
  end

  task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    dbg_valid = 1; dbg_write = 1; dbg_addr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_valid = 0; dbg_write = 0;
  endtask

  task automatic bus_rd(input logic [6:0] a, output logic [31:0] d);
    dbg_addr = a;
    #1;
    d = dbg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 300; i++) begin
      bus_rd(A_ABS, v);
      if (!v[12]) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] cmdw(input logic pe, input logic tr, input logic wr, input logic [15:0] rn);
    return {8'd0, 1'b0, 3'd2, 1'b0, pe, tr, wr, rn};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0;
    for (int i = 0; i < 32; i++) regs[i] = 32'h100 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state, R2
    bus_rd(A_ABS, v);
    chk(v[12] == 0 && v[10:8] == 0, "R8 reset busy/cmderr", v, 32'h0);
    chk(v[28:24] == 5'd2 && v[3:0] == 4'd1, "R2 progbufsize/datacount", v, 32'h0200_0001);
    bus_rd(A_STAT, v);
    chk(v[22] == 1'b1, "R2 impebreak bit", v, 32'h0040_0000);
    bus_rd(A_DATA0, v);
    chk(v == 0, "R3 data0 reset", v, 0);

    // R1 buffer words
    bus_wr(A_PB0, 32'hCAFE_0001);
    bus_wr(A_PB1, 32'hCAFE_0002);
    bus_rd(A_PB0, v); chk(v == 32'hCAFE_0001, "R1 progbuf0 readback", v, 32'hCAFE_0001);
    bus_rd(A_PB1, v); chk(v == 32'hCAFE_0002, "R1 progbuf1 readback", v, 32'hCAFE_0002);

    // R3 write transfer, no postexec
    c0 = inj_cnt;
    bus_wr(A_DATA0, 32'h0000_00A5);
    bus_wr(A_CMD, cmdw(0, 1, 1, 16'h1008));
    bus_rd(A_ABS, v); chk(v[12] == 1'b1, "R8 busy after accept", v, 32'h1000);
    wait_idle();
    chk(regs[8] == 32'hA5, "R3 GPR 8 written from data0", regs[8], 32'hA5);
    chk(inj_cnt == c0, "R5 no injection without postexec", inj_cnt, c0);

    // R4 read transfer
    regs[9] = 32'h0000_1234;
    bus_wr(A_CMD, cmdw(0, 1, 0, 16'h1009));
    wait_idle();
    bus_rd(A_DATA0, v); chk(v == 32'h1234, "R4 data0 from GPR 9", v, 32'h1234);

    // R5/R6 write transfer plus postexec, immediate core
    bus_wr(A_PB0, LW_S0);
    bus_wr(A_PB1, SW_S1);
    bus_wr(A_DATA0, 32'h8000_1000);
    exp_q.push_back(LW_S0); exp_q.push_back(SW_S1); exp_q.push_back(EBRK);
    order_reg = 8; order_val = 32'h8000_1000; order_armed = 1;
    c0 = inj_cnt;
    bus_wr(A_CMD, cmdw(1, 1, 1, 16'h1008));
    wait_idle();
    chk(inj_cnt == c0 + 3, "R5 two words plus ebreak", inj_cnt, c0 + 3);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    bus_rd(A_ABS, v); chk(v[10:8] == 0, "R5 no error after clean run", v[10:8], 0);

    // R6/R8 slow core, postexec only; R9 writes while busy
    core_lat = 5;
    exp_q.push_back(LW_S0); exp_q.push_back(SW_S1); exp_q.push_back(EBRK);
    c0 = inj_cnt;
    bus_wr(A_CMD, cmdw(1, 0, 0, 16'h0));
    repeat (3) @(negedge clk);
    bus_rd(A_ABS, v); chk(v[12] == 1'b1, "R8 busy during injection", v, 32'h1000);
    bus_wr(A_DATA0, 32'hDEAD_BEEF);
    bus_wr(A_PB0, 32'h1111_1111);
    bus_wr(A_CMD, cmdw(0, 1, 1, 16'h1003));
    wait_idle();
    chk(inj_cnt == c0 + 3, "R6 slow core full sequence", inj_cnt, c0 + 3);
    bus_rd(A_ABS, v); chk(v[10:8] == 3'd1, "R9 cmderr busy", v[10:8], 1);
    bus_rd(A_DATA0, v); chk(v == 32'h8000_1000, "R9 data0 write ignored", v, 32'h8000_1000);
    bus_rd(A_PB0, v); chk(v == LW_S0, "R9 progbuf write ignored", v, LW_S0);
    chk(regs[3] == 32'h103, "R9 busy command ignored", regs[3], 32'h103);

    // R10 blocked by pending error, then W1C
    bus_wr(A_CMD, cmdw(0, 1, 1, 16'h1005));
    bus_rd(A_ABS, v); chk(v[12] == 1'b0, "R10 command blocked", v, 0);
    @(negedge clk);
    chk(regs[5] == 32'h105, "R10 GPR untouched", regs[5], 32'h105);
    bus_wr(A_ABS, 32'h0000_0700);
    bus_rd(A_ABS, v); chk(v[10:8] == 0, "R10 W1C clears cmderr", v[10:8], 0);

    // R7 exception stops execution
    core_lat = 2;
    bus_wr(A_PB0, FAULT);
    exp_q.push_back(FAULT);
    c0 = inj_cnt;
    bus_wr(A_CMD, cmdw(1, 0, 0, 16'h0));
    wait_idle();
    repeat (4) @(negedge clk);
    chk(inj_cnt == c0 + 1, "R7 stop after faulting word", inj_cnt, c0 + 1);
    bus_rd(A_ABS, v); chk(v[10:8] == 3'd3, "R7 cmderr exception", v[10:8], 3);
    bus_wr(A_ABS, 32'h0000_0700);

    // R11 unsupported commands
    c0 = inj_cnt;
    bus_wr(A_DATA0, 32'h5555_5555);
    bus_wr(A_CMD, cmdw(1, 1, 1, 16'h1020));
    @(negedge clk);
    bus_rd(A_ABS, v); chk(v[10:8] == 3'd2 && v[12] == 0, "R11 regno out of range", v[10:8], 2);
    chk(inj_cnt == c0, "R11 no injection", inj_cnt, c0);
    bus_wr(A_ABS, 32'h0000_0700);
    bus_wr(A_CMD, {8'd2, 24'h0});
    bus_rd(A_ABS, v); chk(v[10:8] == 3'd2, "R11 nonzero kind", v[10:8], 2);
    bus_wr(A_ABS, 32'h0000_0700);
    bus_wr(A_CMD, {8'd0, 1'b0, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 16'h1001});
    bus_rd(A_ABS, v); chk(v[10:8] == 3'd2, "R11 bad size", v[10:8], 2);
    @(negedge clk);
    chk(regs[1] == 32'h101 && regs[0] == 32'h100, "R11 GPRs untouched", regs[1], 32'h101);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule